// File: doc/BRIEF.md
# Boundary Scan Register with Output-Bus Enable Cell

This block is the boundary data register of a test access port. It has a serial chain of capture/shift stages and a parallel bank of preload latches. A separate TAP controller sequences it through strobes (capture, shift, update, test-logic-reset) and through a 2-bit code for the current instruction. While a boundary instruction is current, a capture strobe takes a snapshot of the device pins into the chain. A shift strobe moves the chain one place toward the serial output, and an update strobe copies the chain into the preload latches. Captured data can be shifted out in the same pass that shifts a new preload pattern in.

When the external-test instruction is current, the preload latches drive the pad outputs in place of the functional outputs. One cell, at index `TRI_IDX` (47 by default), has no pin. Its preload latch gates the whole output bus during external test: a 1 lets the functional enable through to the drivers and a 0 holds the bus at high impedance. That latch is preset to 1 at power-up and on test-logic-reset.

The strobes decode into one operation per cycle. These are the states of the datapath sequencing: `OP_IDLE` (hold), `OP_CAPTURE`, `OP_SHIFT` and `OP_UPDATE`. Any strobe moves the register out of `OP_IDLE` for one cycle, and the register falls back to `OP_IDLE` when no strobe is present. When two strobes arrive together, the priority is update over capture over shift. All strobes are treated as `OP_IDLE` unless the instruction code is 1 (sample/preload) or 2 (external test).

Top module: `bsr_register`

## Requirements
- R1: After `rst_n` is released, every chain stage reads 0 (`tdo` = 0), every preload latch reads 0 except the output-enable cell at `TRI_IDX`, which reads 1.
- R2: While `instr_sel` is 1 or 2, a `capture_dr` cycle loads stage i with `pin_in[i]` for every i except `TRI_IDX`. That stage loads the current output-enable latch value.
- R3: While `instr_sel` is 1 or 2, each `shift_dr` cycle moves stage i+1 into stage i and loads `tdi` into stage N-1. `tdo` always shows stage 0, so bit 0 leaves first, and after N shifts stage k holds the k-th bit shifted in.
- R4: While `instr_sel` is 1 or 2, an `update_dr` cycle without `tlr` copies every chain stage into its preload latch.
- R5: Preload latches hold their values in every cycle without an accepted update or a `tlr`, including during shifting and capture.
- R6: When `instr_sel` is not 2, `pad_out` equals `sys_out` and `pad_oe` equals `sys_oe`, whatever the register does.
- R7: When `instr_sel` is 2, `pad_out[i]` equals preload latch i for every i except `TRI_IDX`, and `pad_out[TRI_IDX]` is 0.
- R8: When `instr_sel` is 2, `pad_oe` equals `sys_oe` AND the output-enable latch, so that latch at 0 disables the bus.
- R9: A `tlr` cycle sets the output-enable latch to 1 and blocks any update in the same cycle. The other latches keep their values.
- R10: When `instr_sel` is 0 or 3, `capture_dr`, `shift_dr` and `update_dr` change neither the chain nor the preload latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| tlr | input | 1 | Controller is in test-logic-reset (synchronous) |
| capture_dr | input | 1 | Capture strobe |
| shift_dr | input | 1 | Shift strobe |
| update_dr | input | 1 | Update strobe |
| instr_sel | input | 2 | Current instruction: 1 sample/preload, 2 external test, 0/3 other |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (stage 0) |
| pin_in | input | N | Pin values to capture |
| sys_out | input | N | Functional output values |
| sys_oe | input | 1 | Functional output-bus enable |
| pad_out | output | N | Values sent to the pad drivers |
| pad_oe | output | 1 | Output-bus enable sent to the pads |

## Verification
A test-logic-reset strobe and an update strobe can land in the same cycle, and both target the output-enable latch. The bench first shifts a pattern with a 0 in the enable cell. It then raises `tlr` and `update_dr` together under the sample/preload code. Under external test, it judges that the bus stays enabled and that `pad_out` still shows the earlier preload pattern, not the shifted one. A capture of the enable cell is also made while that latch is 0 and then 1, to show the cell reads its own latch and not a pin.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

    typedef enum logic [1:0] {
        INS_OTHER0  = 2'd0,
        INS_SAMPLE  = 2'd1,
        INS_EXTEST  = 2'd2,
        INS_OTHER3  = 2'd3
    } bsr_instr_e;

    typedef enum logic [1:0] {
        OP_IDLE    = 2'd0,
        OP_CAPTURE = 2'd1,
        OP_SHIFT   = 2'd2,
        OP_UPDATE  = 2'd3
    } bsr_op_e;

endpackage

// File: rtl/bsr_op_decode.sv
module bsr_op_decode
    import bsr_pkg::*;
(
    input  logic        capture_dr,
    input  logic        shift_dr,
    input  logic        update_dr,
    input  logic [1:0]  instr_sel,
    output bsr_op_e     op,
    output logic        extest
);
    logic selected;

    always_comb begin
        selected = 1'b0;
        extest   = 1'b0;
        unique case (bsr_instr_e'(instr_sel))
            INS_SAMPLE: selected = 1'b1;
            INS_EXTEST: begin
                selected = 1'b1;
                extest   = 1'b1;
            end
            default: ;
        endcase
    end

    always_comb begin
        op = OP_IDLE;
        if (selected) begin
            if (update_dr)       op = OP_UPDATE;
            else if (capture_dr) op = OP_CAPTURE;
            else if (shift_dr)   op = OP_SHIFT;
        end
    end
endmodule

// File: rtl/bsr_shift_chain.sv
module bsr_shift_chain
    import bsr_pkg::*;
#(
    parameter int N = 107
) (
    input  logic          clk,
    input  logic          rst_n,
    input  bsr_op_e       op,
    input  logic          tdi,
    input  logic [N-1:0]  cap_vec,
    output logic [N-1:0]  stage_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            unique case (op)
                OP_CAPTURE: stage_q <= cap_vec;
                OP_SHIFT:   stage_q <= {tdi, stage_q[N-1:1]};
                default:    ;
            endcase
        end
    end

    assert_shift_move_R3: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_SHIFT |=> (stage_q[N-1] == $past(tdi)) &&
                           (stage_q[N-2:0] == $past(stage_q[N-1:1])));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_IDLE || op == OP_UPDATE) |=> $stable(stage_q));
endmodule

// File: rtl/bsr_preload_bank.sv
module bsr_preload_bank #(
    parameter int N       = 107,
    parameter int TRI_IDX = 47
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tlr,
    input  logic          upd_en,
    input  logic [N-1:0]  d,
    output logic [N-1:0]  pre_q
);
    for (genvar g = 0; g < N; g++) begin : g_cell
        if (g == TRI_IDX) begin : g_oe_cell
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      pre_q[g] <= 1'b1;
                else if (tlr)    pre_q[g] <= 1'b1;
                else if (upd_en) pre_q[g] <= d[g];
            end
        end else begin : g_data_cell
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                pre_q[g] <= 1'b0;
                else if (upd_en && !tlr)   pre_q[g] <= d[g];
            end
        end
    end

    assert_tlr_preset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tlr |=> pre_q[TRI_IDX]);

    assert_update_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !tlr) |=> pre_q == $past(d));

    assert_latch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_en && !tlr) |=> $stable(pre_q));
endmodule

// File: rtl/bsr_register.sv
module bsr_register
    import bsr_pkg::*;
#(
    parameter int N       = 107,
    parameter int TRI_IDX = 47
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tlr,
    input  logic          capture_dr,
    input  logic          shift_dr,
    input  logic          update_dr,
    input  logic [1:0]    instr_sel,
    input  logic          tdi,
    output logic          tdo,
    input  logic [N-1:0]  pin_in,
    input  logic [N-1:0]  sys_out,
    input  logic          sys_oe,
    output logic [N-1:0]  pad_out,
    output logic          pad_oe
);
    bsr_op_e      op;
    logic         extest;
    logic [N-1:0] stage_q;
    logic [N-1:0] pre_q;
    logic [N-1:0] cap_vec;
    logic         upd_en;

    bsr_op_decode u_dec (
        .capture_dr (capture_dr),
        .shift_dr   (shift_dr),
        .update_dr  (update_dr),
        .instr_sel  (instr_sel),
        .op         (op),
        .extest     (extest)
    );

    always_comb begin
        cap_vec          = pin_in;
        cap_vec[TRI_IDX] = pre_q[TRI_IDX];
    end

    assign upd_en = (op == OP_UPDATE);

    bsr_shift_chain #(.N(N)) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .tdi     (tdi),
        .cap_vec (cap_vec),
        .stage_q (stage_q)
    );

    bsr_preload_bank #(.N(N), .TRI_IDX(TRI_IDX)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .tlr    (tlr),
        .upd_en (upd_en),
        .d      (stage_q),
        .pre_q  (pre_q)
    );

    assign tdo = stage_q[0];

    for (genvar g = 0; g < N; g++) begin : g_pad
        if (g == TRI_IDX) begin : g_nopin
            assign pad_out[g] = extest ? 1'b0 : sys_out[g];
        end else begin : g_pin
            assign pad_out[g] = extest ? pre_q[g] : sys_out[g];
        end
    end

    assign pad_oe = extest ? (sys_oe & pre_q[TRI_IDX]) : sys_oe;

    assert_func_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_sel != 2'd2) |-> (pad_out == sys_out) && (pad_oe == sys_oe));

    assert_bus_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_sel == 2'd2 && !pre_q[TRI_IDX]) |-> !pad_oe);
endmodule

// File: tb/bsr_register_tb.sv
module bsr_register_tb;
    localparam int N   = 107;
    localparam int TRI = 47;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tlr = 1'b0, capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0;
    logic [1:0] instr_sel = 2'd0;
    logic tdi = 1'b0;
    logic tdo;
    logic [N-1:0] pin_in = '0, sys_out = '0, pad_out;
    logic sys_oe = 1'b1;
    logic pad_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [N-1:0] exp_pre;
    logic [N-1:0] shifted_out;

    always #10 clk = ~clk;

    bsr_register #(.N(N), .TRI_IDX(TRI)) u_dut (
        .clk(clk), .rst_n(rst_n), .tlr(tlr), .capture_dr(capture_dr),
        .shift_dr(shift_dr), .update_dr(update_dr), .instr_sel(instr_sel),
        .tdi(tdi), .tdo(tdo), .pin_in(pin_in), .sys_out(sys_out),
        .sys_oe(sys_oe), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    function automatic logic [N-1:0] pat(input int seed);
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) v[i] = 1'(((i * seed) >> 2) ^ i ^ seed);
        return v;
    endfunction

    function automatic logic [N-1:0] pads_expected(input logic [N-1:0] p);
        logic [N-1:0] v = p;
        v[TRI] = 1'b0;
        return v;
    endfunction

    task automatic check_vec(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_bit(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // one strobe cycle: set at negedge, edge acts, cleared at next negedge
    task automatic pulse(input logic c, input logic s, input logic u, input logic t);
        capture_dr = c; shift_dr = s; update_dr = u; tlr = t;
        @(negedge clk);
        capture_dr = 1'b0; shift_dr = 1'b0; update_dr = 1'b0; tlr = 1'b0;
    endtask

    // N shifts: returns bits seen on tdo, leaves pattern p in the chain
    task automatic shift_all(input logic [N-1:0] p, output logic [N-1:0] seen);
        for (int i = 0; i < N; i++) begin
            seen[i] = tdo;
            tdi = p[i];
            pulse(1'b0, 1'b1, 1'b0, 1'b0);
        end
        tdi = 1'b0;
    endtask

    task automatic t_reset;
        check_bit("R1 tdo after reset", tdo, 1'b0);
        instr_sel = 2'd2; sys_oe = 1'b1; #1;
        check_bit("R1/R8 enable cell preset", pad_oe, 1'b1);
        check_vec("R1/R7 latches cleared", pad_out, '0);
        instr_sel = 2'd1; #1;
        check_vec("R6 functional pass", pad_out, sys_out);
    endtask

    task automatic t_sample_and_preload;
        logic [N-1:0] p = pat(5);
        logic [N-1:0] e;
        p[TRI] = 1'b0;
        pin_in = pat(3);
        sys_out = pat(9);
        instr_sel = 2'd1;
        pulse(1'b1, 1'b0, 1'b0, 1'b0);
        check_bit("R2 first captured bit on tdo", tdo, pin_in[0]);
        shift_all(p, shifted_out);
        e = pin_in; e[TRI] = 1'b1;
        check_vec("R2/R3 captured pins shifted out", shifted_out, e);
        check_vec("R6 pads untouched during sample", pad_out, sys_out);
        check_bit("R6 enable untouched during sample", pad_oe, sys_oe);
        pulse(1'b0, 1'b0, 1'b1, 1'b0);
        exp_pre = p;
        instr_sel = 2'd2; #1;
        check_vec("R4/R7 preload on pads", pad_out, pads_expected(exp_pre));
        check_bit("R8 enable cell 0 disables bus", pad_oe, 1'b0);
    endtask

    task automatic t_extest_hold;
        logic [N-1:0] p = pat(11);
        p[TRI] = 1'b1;
        instr_sel = 2'd2;
        pin_in = pat(13);
        pulse(1'b1, 1'b0, 1'b0, 1'b0);
        check_vec("R5 capture leaves pads", pad_out, pads_expected(exp_pre));
        shift_all(p, shifted_out);
        check_bit("R2 enable cell captured from latch (0)", shifted_out[TRI], 1'b0);
        check_vec("R5 pads held after shifting", pad_out, pads_expected(exp_pre));
        pulse(1'b0, 1'b0, 1'b1, 1'b0);
        exp_pre = p;
        check_vec("R4/R7 extest update", pad_out, pads_expected(exp_pre));
        sys_oe = 1'b0; #1;
        check_bit("R8 functional enable low", pad_oe, 1'b0);
        sys_oe = 1'b1; #1;
        check_bit("R8 enable cell 1 enables bus", pad_oe, 1'b1);
    endtask

    task automatic t_unselected;
        logic [N-1:0] junk;
        instr_sel = 2'd0;
        pin_in = '0;
        pulse(1'b1, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 8; i++) begin
            tdi = 1'b1;
            pulse(1'b0, 1'b1, 1'b0, 1'b0);
        end
        pulse(1'b0, 1'b0, 1'b1, 1'b0);
        instr_sel = 2'd3;
        pulse(1'b0, 1'b1, 1'b1, 1'b0);
        instr_sel = 2'd2; #1;
        check_vec("R10 latches unchanged", pad_out, pads_expected(exp_pre));
        instr_sel = 2'd1;
        shift_all('0, junk);
        check_vec("R10 chain unchanged", junk, exp_pre);
    endtask

    task automatic t_tlr_collision;
        logic [N-1:0] p = pat(7);
        logic [N-1:0] junk;
        instr_sel = 2'd1;
        p[TRI] = 1'b0;
        shift_all('0, junk);
        pulse(1'b0, 1'b0, 1'b1, 1'b0);
        exp_pre = '0;
        instr_sel = 2'd2; #1;
        check_bit("R8 bus disabled before collision", pad_oe, 1'b0);
        instr_sel = 2'd1;
        shift_all(p, junk);
        pulse(1'b0, 1'b0, 1'b1, 1'b1);
        exp_pre[TRI] = 1'b1;
        instr_sel = 2'd2; #1;
        check_bit("R9 tlr wins enable cell", pad_oe, 1'b1);
        check_vec("R9 update blocked", pad_out, pads_expected(exp_pre));
        instr_sel = 2'd1;
        pulse(1'b0, 1'b0, 1'b1, 1'b0);
        instr_sel = 2'd2; #1;
        check_bit("R4 later update loads 0", pad_oe, 1'b0);
        pulse(1'b0, 1'b0, 1'b0, 1'b1);
        check_bit("R9 tlr alone presets", pad_oe, 1'b1);
        check_vec("R9 other latches kept", pad_out, pads_expected(p));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sample_and_preload();
        t_extest_hold();
        t_unselected();
        t_tlr_collision();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule